// File: doc/BRIEF.md
# SPI Serial Clock Generator

This block derives the serial clock of an SPI master from its functional clock. A transfer begins with a start pulse that carries three settings: an 8-bit divide code, the clock polarity and phase bits, and a bit count. For an ordinary code `div`, each half-period of SCLK lasts `div+1` functional cycles, so SCLK runs at the functional rate divided by `(div+1)*2`. The all-ones code is reserved and selects bypass. In bypass every functional cycle carries one full SCLK period, so SCLK runs at the functional clock rate. The largest ordinary code is 0xFE.

Alongside SCLK the block gives two single-cycle strobes for the shift engine, one for shifting data out and one for sampling data in. Which SCLK edge drives each strobe depends on the phase bit. Settings are captured when a transfer starts and do not change during it. Between transfers SCLK rests at the polarity level currently presented on the inputs. After the final data edge SCLK stops toggling.

Top module: `spi_sclk_gen`

## Requirements
- R1: While no transfer is active, `busy_o`, `shift_stb_o` and `sample_stb_o` are 0 and `sclk_o` equals `cpol_i`, following it combinationally. This also holds after reset.
- R2: For a code other than 0xFF, the first SCLK toggle happens at the clock edge that ends busy cycle `div` (cycles counted from 0 after the accepting edge). Every later half-period lasts exactly `div+1` cycles, so the first half-period always has its full length.
- R3: For a code other than 0xFF, a transfer of `n` bits keeps `busy_o` high for `2*n*(div+1)` cycles. During that time SCLK makes exactly `2*n` toggles and ends at the captured polarity.
- R4: Code 0xFF (bypass) keeps `busy_o` high for `n` cycles. In each busy cycle `sclk_o` equals the polarity while the functional clock is high and its inverse while the functional clock is low.
- R5: With phase 1, `shift_stb_o` fires on every leading edge and `sample_stb_o` on every trailing edge. A leading edge is a toggle away from the idle level.
- R6: With phase 0, `sample_stb_o` fires on every leading edge and `shift_stb_o` on every trailing edge except the last. The first bit is presented before the first edge, so it needs no strobe.
- R7: A strobe is high only during a busy cycle, and only in the cycle whose closing clock edge makes the SCLK toggle it marks.
- R8: A start is ignored while a transfer is active, and also when the bit count is 0. Changes to the divide code, polarity or phase during a transfer do not affect that transfer.
- R9: In bypass, `sample_stb_o` is high in every busy cycle. `shift_stb_o` is high in every busy cycle with phase 1, and in every busy cycle except the last with phase 0.
- R10: Code 0xFE is an ordinary code and gives half-periods of 255 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Functional clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Requests a transfer; captures the settings |
| div_i | input | DIV_W | Divide code; all ones selects bypass |
| cpol_i | input | 1 | Clock polarity, the SCLK idle level |
| cpha_i | input | 1 | Clock phase; 1 shifts on leading edges |
| nbits_i | input | LEN_W | Number of bits in the transfer |
| sclk_o | output | 1 | Serial clock |
| shift_stb_o | output | 1 | One-cycle strobe: shift the next bit out |
| sample_stb_o | output | 1 | One-cycle strobe: sample the incoming bit |
| busy_o | output | 1 | A transfer is in progress |

## Verification
The assertions check, on every cycle, the properties that hold from one clock edge to the next. They cover: the idle level, strobes that appear only while busy, SCLK that holds between divider ticks and toggles on each tick, a suppressed final shift with phase 0, a sample strobe in every bypass cycle, and a zero-length start that is refused. Other properties need a known stimulus history, so only the bench's scenarios can show them. These are the absolute half-period length for a given code, the total busy length, the edge role assigned to each strobe across a whole transfer, the sub-cycle SCLK waveform in bypass, and the immunity of a running transfer to changed settings.

// File: rtl/sclk_div_pkg.sv
`timescale 1ns/1ps
package sclk_div_pkg;

  // Kind of SCLK event in the current cycle; bit 0 = leading, bit 1 = trailing.
  typedef enum logic [1:0] {
    EDGE_NONE  = 2'b00,
    EDGE_LEAD  = 2'b01,
    EDGE_TRAIL = 2'b10,
    EDGE_BOTH  = 2'b11
  } edge_kind_e;

  // Classify a divider tick. In bypass one cycle holds both edges of a bit.
  function automatic edge_kind_e edge_kind_of(logic tick, logic bypass, logic at_idle);
    if (!tick)       return EDGE_NONE;
    else if (bypass) return EDGE_BOTH;
    else if (at_idle) return EDGE_LEAD;
    else             return EDGE_TRAIL;
  endfunction

  // Phase 1 shifts on leading edges; phase 0 shifts on trailing edges but not the final one.
  function automatic logic shift_role(edge_kind_e k, logic cpha, logic last);
    logic [1:0] b;
    b = k;
    return cpha ? b[0] : (b[1] & ~last);
  endfunction

  // Sampling happens on the edge that does not shift.
  function automatic logic sample_role(edge_kind_e k, logic cpha);
    logic [1:0] b;
    b = k;
    return cpha ? b[1] : b[0];
  endfunction

endpackage

// File: rtl/sclk_half_timer.sv
`timescale 1ns/1ps
module sclk_half_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [DIV_W-1:0] load_val_i,
  input  logic             run_i,
  input  logic [DIV_W-1:0] reload_val_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  // Counts down one half-period; reloaded at start so the first half is full length.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (load_i)             cnt_q <= load_val_i;
    else if (run_i) begin
      if (cnt_q == '0)           cnt_q <= reload_val_i;
      else                       cnt_q <= cnt_q - 1'b1;
    end
  end

  assign tick_o = run_i && (cnt_q == '0);
endmodule

// File: rtl/sclk_edge_track.sv
`timescale 1ns/1ps
module sclk_edge_track #(
  parameter int   EDGE_W   = 7,
  parameter logic IDLE_RST = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [EDGE_W-1:0] total_i,
  input  logic              level_i,
  input  logic              tick_i,
  input  logic              bypass_i,
  input  logic              cpol_i,
  output logic              sclk_q_o,
  output logic              busy_o,
  output logic              last_o,
  output sclk_div_pkg::edge_kind_e kind_o
);
  logic [EDGE_W-1:0] left_q;
  logic              sclk_q;

  // Remaining events (edges, or bits in bypass) and the registered SCLK level.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q <= '0;
      sclk_q <= IDLE_RST;
    end else if (load_i) begin
      left_q <= total_i;
      sclk_q <= level_i;
    end else if (tick_i) begin
      left_q <= left_q - 1'b1;
      if (!bypass_i) sclk_q <= ~sclk_q;
    end
  end

  assign busy_o   = (left_q != '0);
  assign last_o   = (left_q == {{(EDGE_W-1){1'b0}}, 1'b1});
  assign sclk_q_o = sclk_q;
  assign kind_o   = sclk_div_pkg::edge_kind_of(tick_i, bypass_i, sclk_q == cpol_i);
endmodule

// File: rtl/spi_sclk_gen.sv
`timescale 1ns/1ps
module spi_sclk_gen #(
  parameter int   DIV_W    = 8,
  parameter int   LEN_W    = 6,
  parameter logic IDLE_RST = 1'b1,
  localparam int  EDGE_W   = LEN_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             cpol_i,
  input  logic             cpha_i,
  input  logic [LEN_W-1:0] nbits_i,
  output logic             sclk_o,
  output logic             shift_stb_o,
  output logic             sample_stb_o,
  output logic             busy_o
);
  import sclk_div_pkg::*;

  logic             busy_w, accept_w, byp_now, tick_w, last_w, trail_w, lead_w;
  logic             sclk_q, cpol_l, cpha_l, byp_l;
  logic [DIV_W-1:0] div_l, load_val, reload_val;
  logic [EDGE_W-1:0] total_w;
  edge_kind_e       kind_w;

  assign byp_now  = &div_i;
  assign accept_w = start_i && !busy_w && (nbits_i != '0);

  // Settings frozen for the length of a transfer.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_l  <= '0;
      cpol_l <= IDLE_RST;
      cpha_l <= 1'b1;
      byp_l  <= 1'b0;
    end else if (accept_w) begin
      div_l  <= div_i;
      cpol_l <= cpol_i;
      cpha_l <= cpha_i;
      byp_l  <= byp_now;
    end
  end

  assign load_val   = byp_now ? '0 : div_i;
  assign reload_val = byp_l   ? '0 : div_l;
  assign total_w    = byp_now ? {1'b0, nbits_i} : {nbits_i, 1'b0};

  sclk_half_timer #(.DIV_W(DIV_W)) u_timer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (accept_w),
    .load_val_i   (load_val),
    .run_i        (busy_w),
    .reload_val_i (reload_val),
    .tick_o       (tick_w)
  );

  sclk_edge_track #(.EDGE_W(EDGE_W), .IDLE_RST(IDLE_RST)) u_edges (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (accept_w),
    .total_i  (total_w),
    .level_i  (cpol_i),
    .tick_i   (tick_w),
    .bypass_i (byp_l),
    .cpol_i   (cpol_l),
    .sclk_q_o (sclk_q),
    .busy_o   (busy_w),
    .last_o   (last_w),
    .kind_o   (kind_w)
  );

  assign lead_w  = kind_w[0];
  assign trail_w = kind_w[1];

  assign shift_stb_o  = shift_role(kind_w, cpha_l, last_w);
  assign sample_stb_o = sample_role(kind_w, cpha_l);
  assign busy_o       = busy_w;

  // Bypass: a full SCLK period inside each functional cycle, leading edge at mid-cycle.
  assign sclk_o = busy_w ? (sclk_q ^ (byp_l & ~clk_i)) : cpol_i;
endmodule

// File: rtl/spi_sclk_gen_chk.sv
`timescale 1ns/1ps
module spi_sclk_gen_chk #(
  parameter int LEN_W = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             cpol_i,
  input logic [LEN_W-1:0] nbits_i,
  input logic             sclk_o,
  input logic             shift_stb_o,
  input logic             sample_stb_o,
  input logic             busy_o,
  input logic             sclk_q,
  input logic             tick_w,
  input logic             byp_l,
  input logic             cpha_l,
  input logic             last_w,
  input logic             trail_w
);
  p_idle_level_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (sclk_o == cpol_i) && !shift_stb_o && !sample_stb_o);

  p_strobe_in_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_stb_o || sample_stb_o) |-> busy_o);

  p_hold_between_ticks_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !byp_l && !tick_w) |=> (sclk_q == $past(sclk_q)));

  p_toggle_on_tick_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_w && !byp_l) |=> (sclk_q != $past(sclk_q)));

  p_no_final_shift_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !cpha_l && last_w && trail_w) |-> !shift_stb_o);

  p_bypass_sample_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && byp_l) |-> sample_stb_o);

  p_zero_len_refused_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && (nbits_i == '0)) |=> !busy_o);
endmodule

bind spi_sclk_gen spi_sclk_gen_chk #(.LEN_W(LEN_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .cpol_i       (cpol_i),
  .nbits_i      (nbits_i),
  .sclk_o       (sclk_o),
  .shift_stb_o  (shift_stb_o),
  .sample_stb_o (sample_stb_o),
  .busy_o       (busy_o),
  .sclk_q       (sclk_q),
  .tick_w       (tick_w),
  .byp_l        (byp_l),
  .cpha_l       (cpha_l),
  .last_w       (last_w),
  .trail_w      (trail_w)
);

// File: tb/spi_sclk_gen_bench.sv
`timescale 1ns/1ps
module spi_sclk_gen_bench;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [7:0] div_i = 8'd0;
  logic       cpol_i = 1'b1;
  logic       cpha_i = 1'b1;
  logic [5:0] nbits_i = 6'd0;
  logic       sclk_o, shift_stb_o, sample_stb_o, busy_o;
  int         total = 0;
  int         bad = 0;

  always #2.5 clk = ~clk;

  spi_sclk_gen u_spi_sclk_gen (
    .clk_i (clk), .rst_ni (rst_ni), .start_i (start_i), .div_i (div_i),
    .cpol_i (cpol_i), .cpha_i (cpha_i), .nbits_i (nbits_i),
    .sclk_o (sclk_o), .shift_stb_o (shift_stb_o),
    .sample_stb_o (sample_stb_o), .busy_o (busy_o)
  );

  task automatic chk(input string rid, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%0b exp=%0b t=%0t", rid, what, act, exp, $time);
    end
  endtask

  task automatic next_cycle();
    @(posedge clk); #1;
  endtask

  // Ordinary code: a transfer, checked every cycle (R2 R3 R5 R6 R7; R8 when disturbed).
  task automatic run_normal(input logic [7:0] d, input logic cp, input logic ph,
                            input logic [5:0] n, input bit disturb);
    int h, len, e, pos;
    logic tick, lead, trail, last;
    h = int'(d) + 1;
    len = 2 * int'(n) * h;
    div_i = d; cpol_i = cp; cpha_i = ph; nbits_i = n; start_i = 1'b1;
    next_cycle();
    start_i = 1'b0;
    for (int k = 0; k <= len; k++) begin
      if (disturb && k == 2) begin
        div_i = ~d; cpol_i = ~cp; cpha_i = ~ph; start_i = 1'b1;
      end
      if (disturb && k == 3) start_i = 1'b0;
      e = k / h; pos = k % h;
      tick  = (k < len) && (pos == h - 1);
      lead  = tick && (e % 2 == 0);
      trail = tick && (e % 2 == 1);
      last  = (e == 2 * int'(n) - 1);
      chk("R3", "busy", busy_o, k < len);
      chk("R2", "sclk", sclk_o, (k < len) ? (cp ^ logic'(e % 2)) : cpol_i);
      if (ph) begin
        chk("R5", "shift", shift_stb_o, lead);
        chk("R5", "sample", sample_stb_o, trail);
      end else begin
        chk("R6", "shift", shift_stb_o, trail && !last);
        chk("R6", "sample", sample_stb_o, lead);
      end
      if (disturb && k > 2) chk("R8", "ignored mid-change", busy_o, k < len);
      next_cycle();
    end
  endtask

  // Bypass code: both phases of the clock are checked (R4 R9).
  task automatic run_bypass(input logic cp, input logic ph, input logic [5:0] n);
    div_i = 8'hFF; cpol_i = cp; cpha_i = ph; nbits_i = n; start_i = 1'b1;
    next_cycle();
    start_i = 1'b0;
    for (int k = 0; k <= int'(n); k++) begin
      chk("R4", "busy", busy_o, k < int'(n));
      chk("R4", "sclk high phase", sclk_o, cp);
      chk("R9", "sample", sample_stb_o, k < int'(n));
      chk("R9", "shift", shift_stb_o, (k < int'(n)) && (ph || k != int'(n) - 1));
      #2.5;
      chk("R4", "sclk low phase", sclk_o, (k < int'(n)) ? ~cp : cp);
      next_cycle();
    end
  endtask

  task automatic test_reset();
    chk("R1", "reset busy", busy_o, 1'b0);
    chk("R1", "reset shift", shift_stb_o, 1'b0);
    chk("R1", "reset sample", sample_stb_o, 1'b0);
    chk("R1", "reset sclk", sclk_o, cpol_i);
  endtask

  task automatic test_idle_follow();
    cpol_i = 1'b0; #1;
    chk("R1", "idle low", sclk_o, 1'b0);
    cpol_i = 1'b1; #1;
    chk("R1", "idle high", sclk_o, 1'b1);
    next_cycle();
  endtask

  task automatic test_zero_len();
    div_i = 8'd1; nbits_i = 6'd0; start_i = 1'b1;
    next_cycle();
    start_i = 1'b0;
    for (int k = 0; k < 3; k++) begin
      chk("R8", "zero length ignored", busy_o, 1'b0);
      chk("R8", "zero length sclk", sclk_o, cpol_i);
      next_cycle();
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    next_cycle();
    test_reset();
    test_idle_follow();
    run_normal(8'd0, 1'b1, 1'b1, 6'd4, 1'b0);
    run_normal(8'd2, 1'b0, 1'b0, 6'd3, 1'b0);
    run_normal(8'd5, 1'b1, 1'b0, 6'd2, 1'b0);
    run_normal(8'd1, 1'b0, 1'b1, 6'd5, 1'b1);
    run_bypass(1'b1, 1'b1, 6'd6);
    run_bypass(1'b0, 1'b0, 6'd3);
    run_normal(8'hFE, 1'b1, 1'b1, 6'd1, 1'b0);  // R10
    test_zero_len();
    run_normal(8'd3, 1'b0, 1'b0, 6'd1, 1'b0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule